// File: doc/BRIEF.md
# Processor trace status encoder

This block turns per-cycle events from a processor core into two 4-bit trace ports. The status port carries a code for what the core did in a cycle. The data port carries the target addresses of certain taken branches, one nibble per cycle. The ordinary events are an instruction start, a taken branch and the start of a return from exception. A branch whose target comes from a register, a stack or a vector is flagged as variable. For such a branch the block can stream the target address after it: first a byte-count marker on the status port, then the address nibbles on the data port.

Four multi-cycle modes override the ordinary reporting: exception processing, emulator entry, stopped and halted. Each mode keeps its code on the status port until the core signals that the mode has ended. A 2-bit configuration input turns address display off or selects 2, 3 or 4 bytes.

If a second captured branch arrives while an address is still streaming, it goes into a one-entry buffer. While that buffer is full, a stall output tells the core to hold off. All outputs are registered. A code for the events sampled at one clock edge appears on the ports right after that edge.

Top module: `trace_status_encoder`

State machines:
- The mode machine has five states: RUN, EXC, EMU, STOP and HALT.
  - From RUN it enters HALT, EMU, EXC or STOP, in that order of priority, on the matching entry input.
  - EXC and EMU return to RUN on `exc_done_i`.
  - STOP returns to RUN on `wake_i`.
  - HALT returns to RUN on `restart_i`.
  - Every state except HALT goes to HALT on `halt_enter_i`.
- The address serializer has three states: IDLE, MARK and DATA.
  - IDLE moves to MARK when a branch is captured.
  - MARK moves to DATA once the marker is put on the status port.
  - DATA moves to MARK after its last nibble if another address is waiting, and otherwise to IDLE.

## Requirements
- R1: Outside the multi-cycle modes, the status port shows a code for the events sampled at the previous clock edge.
  - 0x5 for a taken branch.
  - 0x7 for a return-from-exception start.
  - 0x1 for an instruction start.
  - 0x0 for none.
  - When several events coincide, the order of priority is branch, then return, then instruction start.
- R2: A taken branch with `branch_var_i` high and a non-zero `addr_cfg_i` is captured and shows 0x5. In the next cycle the status port shows the marker 0x8 + `addr_cfg_i`: 0x9 for 2 bytes, 0xA for 3 bytes, 0xB for 4 bytes. The marker replaces any ordinary code of that cycle.
- R3: In the cycles right after the marker, the data port shows the captured address.
  - Bytes go out least significant first, and within each byte the low nibble goes out first.
  - An N-byte address takes 2N cycles.
  - At all other times the data port reads 0x0.
- R4: A taken branch without `branch_var_i`, or one with `addr_cfg_i` = 0, shows 0x5 only, with no marker and no data.
- R5: Exception processing shows 0xC and emulator entry shows 0xD. The code holds in every cycle until `exc_done_i`. Emulator entry wins over exception entry in the same cycle.
- R6: A stop shows 0xE until `wake_i`. A halt shows 0xF until `restart_i`. Halt entry wins over every other event.
- R7: Mode codes take priority over branch and marker codes.
  - Branches are not captured while the next mode is not RUN.
  - A marker that is due during a mode waits until the mode exits.
  - Address nibbles that are already streaming continue during a mode.
- R8: A branch captured while another address is streaming is buffered, and `stall_o` stays high while the buffer is full.
  - The buffered marker follows the last nibble of the current address directly.
  - A capture that coincides with that last nibble, while the buffer is empty, starts its own sequence directly.
- R9: Reset, asynchronous and active low, returns both ports to 0x0 and `stall_o` to 0. It also discards any address that is streaming or buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_start_i | input | 1 | An instruction starts this cycle |
| branch_taken_i | input | 1 | A taken branch executes this cycle |
| branch_var_i | input | 1 | The taken branch has a variable target address |
| rte_start_i | input | 1 | A return from exception starts |
| exc_enter_i | input | 1 | Exception processing begins |
| emu_enter_i | input | 1 | Emulator-mode entry begins |
| exc_done_i | input | 1 | Exception or emulator entry processing has completed |
| stop_enter_i | input | 1 | The core stops |
| wake_i | input | 1 | An interrupt ends the stop |
| halt_enter_i | input | 1 | The core halts |
| restart_i | input | 1 | The halted core restarts |
| target_addr_i | input | ADDR_W | Branch target address |
| addr_cfg_i | input | 2 | 0 = no address, 1/2/3 = 2/3/4 bytes |
| status_o | output | 4 | Status code |
| ddata_o | output | 4 | Address nibble, or 0x0 when idle |
| stall_o | output | 1 | The pending-address buffer is full |

## Verification
The bench walks a cycle-by-cycle script of events. It contrasts captured branches at each byte count with plain branches and with captures turned off, so the marker value and the stream length separate the three widths. Mode entries and exits are placed while a stream runs, and one capture is placed just before a mode entry. These show that mode codes win while the data nibbles keep flowing and the waiting marker is deferred. The remaining directed cases are listed below.
- A second capture during streaming, which separates buffering and stall from the direct start.
- A capture landing on the final nibble.
- A reset in the middle of a stream.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [2:0] {
        MODE_RUN,
        MODE_EXC,
        MODE_EMU,
        MODE_STOP,
        MODE_HALT
    } mode_e;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_MARK,
        SER_DATA
    } ser_e;

    localparam logic [3:0] ST_NONE      = 4'h0;
    localparam logic [3:0] ST_INSN      = 4'h1;
    localparam logic [3:0] ST_BRANCH    = 4'h5;
    localparam logic [3:0] ST_RTE       = 4'h7;
    localparam logic [3:0] ST_MARK_BASE = 4'h8;
    localparam logic [3:0] ST_EXC       = 4'hC;
    localparam logic [3:0] ST_EMU       = 4'hD;
    localparam logic [3:0] ST_STOP      = 4'hE;
    localparam logic [3:0] ST_HALT      = 4'hF;

    function automatic logic [3:0] mode_code(input mode_e m);
        logic [3:0] c;
        unique case (m)
            MODE_EXC:  c = ST_EXC;
            MODE_EMU:  c = ST_EMU;
            MODE_STOP: c = ST_STOP;
            MODE_HALT: c = ST_HALT;
            default:   c = ST_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/trace_mode_fsm.sv
module trace_mode_fsm
    import trace_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  exc_enter,
    input  logic  emu_enter,
    input  logic  exc_done,
    input  logic  stop_enter,
    input  logic  wake,
    input  logic  halt_enter,
    input  logic  restart,
    output mode_e mode_nxt
);

    mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_nxt;
    end

    always_comb begin
        mode_nxt = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (halt_enter)      mode_nxt = MODE_HALT;
                else if (emu_enter)  mode_nxt = MODE_EMU;
                else if (exc_enter)  mode_nxt = MODE_EXC;
                else if (stop_enter) mode_nxt = MODE_STOP;
            end
            MODE_EXC, MODE_EMU: begin
                if (halt_enter)    mode_nxt = MODE_HALT;
                else if (exc_done) mode_nxt = MODE_RUN;
            end
            MODE_STOP: begin
                if (halt_enter) mode_nxt = MODE_HALT;
                else if (wake)  mode_nxt = MODE_RUN;
            end
            MODE_HALT: begin
                if (restart) mode_nxt = MODE_RUN;
            end
            default: mode_nxt = MODE_RUN;
        endcase
    end

endmodule

// File: rtl/trace_addr_serializer.sv
module trace_addr_serializer
    import trace_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [1:0]        cap_sel,
    input  logic              mark_ok,
    output logic              mark_fire,
    output logic [3:0]        mark_code,
    output logic [3:0]        ddata,
    output logic              full
);

    localparam int NIB_MAX = ADDR_W / 4;
    localparam int CNT_W   = $clog2(NIB_MAX + 1);

    ser_e              state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [ADDR_W-1:0] shift_q, shift_n;
    logic [1:0]        sel_q, sel_n;
    logic              pv_q, pv_n;
    logic [ADDR_W-1:0] pa_q, pa_n;
    logic [1:0]        ps_q, ps_n;
    logic [3:0]        dd_q, dd_n;
    logic              last, free;
    logic [CNT_W-1:0]  nib_total;

    assign nib_total = CNT_W'({sel_q, 1'b0}) + CNT_W'(2);
    assign last      = (state_q == SER_DATA) && (cnt_q == CNT_W'(1));
    assign free      = (state_q == SER_IDLE) || last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            sel_q   <= '0;
            pv_q    <= 1'b0;
            pa_q    <= '0;
            ps_q    <= '0;
            dd_q    <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            shift_q <= shift_n;
            sel_q   <= sel_n;
            pv_q    <= pv_n;
            pa_q    <= pa_n;
            ps_q    <= ps_n;
            dd_q    <= dd_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        shift_n = shift_q;
        sel_n   = sel_q;
        pv_n    = pv_q;
        pa_n    = pa_q;
        ps_n    = ps_q;
        dd_n    = 4'h0;
        unique case (state_q)
            SER_IDLE: ;
            SER_MARK: begin
                if (mark_ok) begin
                    state_n = SER_DATA;
                    cnt_n   = nib_total;
                end
            end
            SER_DATA: begin
                dd_n    = shift_q[3:0];
                shift_n = shift_q >> 4;
                cnt_n   = cnt_q - CNT_W'(1);
            end
            default: state_n = SER_IDLE;
        endcase
        if (free) begin
            if (pv_q) begin
                shift_n = pa_q;
                sel_n   = ps_q;
                state_n = SER_MARK;
                pv_n    = cap;
                if (cap) begin
                    pa_n = cap_addr;
                    ps_n = cap_sel;
                end
            end else if (cap) begin
                shift_n = cap_addr;
                sel_n   = cap_sel;
                state_n = SER_MARK;
            end else if (last) begin
                state_n = SER_IDLE;
            end
        end else if (cap && !pv_q) begin
            pv_n = 1'b1;
            pa_n = cap_addr;
            ps_n = cap_sel;
        end
    end

    always_comb begin
        mark_fire = (state_q == SER_MARK) && mark_ok;
        mark_code = ST_MARK_BASE | {2'b00, sel_q};
        ddata     = dd_q;
        full      = pv_q;
    end

endmodule

// File: rtl/trace_status_encoder.sv
module trace_status_encoder
    import trace_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_start_i,
    input  logic              branch_taken_i,
    input  logic              branch_var_i,
    input  logic              rte_start_i,
    input  logic              exc_enter_i,
    input  logic              emu_enter_i,
    input  logic              exc_done_i,
    input  logic              stop_enter_i,
    input  logic              wake_i,
    input  logic              halt_enter_i,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] target_addr_i,
    input  logic [1:0]        addr_cfg_i,
    output logic [3:0]        status_o,
    output logic [3:0]        ddata_o,
    output logic              stall_o
);

    mode_e      mode_nxt;
    logic       running, cap, mark_fire;
    logic [3:0] mark_code, run_code, status_d, status_q;

    trace_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter_i),
        .emu_enter  (emu_enter_i),
        .exc_done   (exc_done_i),
        .stop_enter (stop_enter_i),
        .wake       (wake_i),
        .halt_enter (halt_enter_i),
        .restart    (restart_i),
        .mode_nxt   (mode_nxt)
    );

    assign running = (mode_nxt == MODE_RUN);
    assign cap     = running && branch_taken_i && branch_var_i && (addr_cfg_i != 2'b00);

    trace_addr_serializer #(.ADDR_W(ADDR_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .cap_addr  (target_addr_i),
        .cap_sel   (addr_cfg_i),
        .mark_ok   (running),
        .mark_fire (mark_fire),
        .mark_code (mark_code),
        .ddata     (ddata_o),
        .full      (stall_o)
    );

    always_comb begin
        if (branch_taken_i)    run_code = ST_BRANCH;
        else if (rte_start_i)  run_code = ST_RTE;
        else if (insn_start_i) run_code = ST_INSN;
        else                   run_code = ST_NONE;

        if (!running)       status_d = mode_code(mode_nxt);
        else if (mark_fire) status_d = mark_code;
        else                status_d = run_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= ST_NONE;
        else        status_q <= status_d;
    end

    assign status_o = status_q;

endmodule

// File: rtl/trace_status_checker.sv
module trace_status_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_start_i,
    input logic              branch_taken_i,
    input logic              branch_var_i,
    input logic              rte_start_i,
    input logic              exc_enter_i,
    input logic              emu_enter_i,
    input logic              exc_done_i,
    input logic              stop_enter_i,
    input logic              wake_i,
    input logic              halt_enter_i,
    input logic              restart_i,
    input logic [ADDR_W-1:0] target_addr_i,
    input logic [1:0]        addr_cfg_i,
    input logic [3:0]        status_o,
    input logic [3:0]        ddata_o,
    input logic              stall_o
);

    assert_exc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 4'hC && !exc_done_i && !halt_enter_i) |=> status_o == 4'hC);

    assert_emu_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 4'hD && !exc_done_i && !halt_enter_i) |=> status_o == 4'hD);

    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 4'hE && !wake_i && !halt_enter_i) |=> status_o == 4'hE);

    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 4'hF && !restart_i) |=> status_o == 4'hF);

    assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(branch_taken_i && branch_var_i));

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (status_o == 4'h0 && ddata_o == 4'h0 && !stall_o));

endmodule

bind trace_status_encoder trace_status_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_trace_status_encoder.sv
module test_trace_status_encoder;

    typedef struct packed {
        logic [10:0] ev;
        logic [31:0] addr;
        logic [1:0]  cfg;
        logic [3:0]  st;
        logic [3:0]  dd;
        logic        stall;
    } vec_t;

    localparam logic [10:0] INSN = 11'h001, BR = 11'h002, VAR = 11'h004, RTE = 11'h008,
                            EXC = 11'h010, EMU = 11'h020, DONE = 11'h040, STOP = 11'h080,
                            WAKE = 11'h100, HALT = 11'h200, RSTR = 11'h400;
    localparam int NV = 40;

    localparam vec_t VEC [0:NV-1] = '{
        '{INSN,     32'h0,        2'd1, 4'h1, 4'h0, 1'b0}, // R1
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R1
        '{RTE,      32'h0,        2'd1, 4'h7, 4'h0, 1'b0}, // R1
        '{BR|VAR,   32'h0000ABCD, 2'd1, 4'h5, 4'h0, 1'b0}, // R2 capture, 2 bytes
        '{INSN,     32'h0,        2'd1, 4'h9, 4'h0, 1'b0}, // R2 marker displaces 0x1
        '{INSN,     32'h0,        2'd1, 4'h1, 4'hD, 1'b0}, // R3
        '{BR,       32'h0,        2'd1, 4'h5, 4'hC, 1'b0}, // R4 plain branch
        '{BR|VAR,   32'h12345678, 2'd3, 4'h5, 4'hB, 1'b1}, // R8 buffered, stall
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'hA, 1'b0}, // R3 last nibble
        '{11'h0,    32'h0,        2'd1, 4'hB, 4'h0, 1'b0}, // R8 marker right after
        '{INSN,     32'h0,        2'd1, 4'h1, 4'h8, 1'b0}, // R3
        '{EXC,      32'h0,        2'd1, 4'hC, 4'h7, 1'b0}, // R5 R7 stream goes on
        '{11'h0,    32'h0,        2'd1, 4'hC, 4'h6, 1'b0}, // R5
        '{DONE,     32'h0,        2'd1, 4'h0, 4'h5, 1'b0}, // R5 exit
        '{STOP,     32'h0,        2'd1, 4'hE, 4'h4, 1'b0}, // R6
        '{11'h0,    32'h0,        2'd1, 4'hE, 4'h3, 1'b0}, // R6
        '{WAKE|INSN,32'h0,        2'd1, 4'h1, 4'h2, 1'b0}, // R6 exit
        '{HALT,     32'h0,        2'd1, 4'hF, 4'h1, 1'b0}, // R6
        '{11'h0,    32'h0,        2'd1, 4'hF, 4'h0, 1'b0}, // R6 R3 idle
        '{RSTR,     32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R6 exit
        '{EMU,      32'h0,        2'd1, 4'hD, 4'h0, 1'b0}, // R5
        '{DONE|INSN,32'h0,        2'd1, 4'h1, 4'h0, 1'b0}, // R5 exit
        '{BR|VAR,   32'hFFFF0000, 2'd0, 4'h5, 4'h0, 1'b0}, // R4 display off
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R4 no marker
        '{BR|VAR,   32'h00000321, 2'd2, 4'h5, 4'h0, 1'b0}, // R2 3 bytes
        '{EXC,      32'h0,        2'd1, 4'hC, 4'h0, 1'b0}, // R7 marker waits
        '{DONE,     32'h0,        2'd1, 4'hA, 4'h0, 1'b0}, // R7 R2 marker after exit
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h1, 1'b0}, // R3
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h2, 1'b0}, // R3
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h3, 1'b0}, // R3
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R3
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R3
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R3 sixth nibble
        '{BR|VAR|HALT, 32'hFFFFFFFF, 2'd3, 4'hF, 4'h0, 1'b0}, // R7 R6 halt wins
        '{RSTR,     32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R7
        '{11'h0,    32'h0,        2'd1, 4'h0, 4'h0, 1'b0}, // R7 nothing captured
        '{BR|RTE,   32'h0,        2'd1, 4'h5, 4'h0, 1'b0}, // R1 priority
        '{RTE|INSN, 32'h0,        2'd1, 4'h7, 4'h0, 1'b0}, // R1 priority
        '{EXC|EMU,  32'h0,        2'd1, 4'hD, 4'h0, 1'b0}, // R5 emu wins
        '{DONE,     32'h0,        2'd1, 4'h0, 4'h0, 1'b0}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_start_i = 0, branch_taken_i = 0, branch_var_i = 0, rte_start_i = 0;
    logic        exc_enter_i = 0, emu_enter_i = 0, exc_done_i = 0, stop_enter_i = 0;
    logic        wake_i = 0, halt_enter_i = 0, restart_i = 0;
    logic [31:0] target_addr_i = '0;
    logic [1:0]  addr_cfg_i = '0;
    logic [3:0]  status_o, ddata_o;
    logic        stall_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trace_status_encoder #(.ADDR_W(32)) i_trace_status_encoder (.*);

    task automatic drive(input logic [10:0] ev, input logic [31:0] a, input logic [1:0] c);
        @(negedge clk);
        {restart_i, halt_enter_i, wake_i, stop_enter_i, exc_done_i, emu_enter_i,
         exc_enter_i, rte_start_i, branch_var_i, branch_taken_i, insn_start_i} = ev;
        target_addr_i = a;
        addr_cfg_i    = c;
    endtask

    task automatic check(input string tag, input logic [3:0] est, input logic [3:0] edd,
                         input logic estall);
        checks++;
        if (status_o !== est || ddata_o !== edd || stall_o !== estall) begin
            errors++;
            $display("FAIL %s: status=%h ddata=%h stall=%b expected status=%h ddata=%h stall=%b",
                     tag, status_o, ddata_o, stall_o, est, edd, estall);
        end
    endtask

    task automatic step(input string tag, input logic [10:0] ev, input logic [31:0] a,
                        input logic [1:0] c, input logic [3:0] est, input logic [3:0] edd,
                        input logic estall);
        drive(ev, a, c);
        @(posedge clk);
        #2;
        check(tag, est, edd, estall);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset state", 4'h0, 4'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step($sformatf("table row %0d", i), VEC[i].ev, VEC[i].addr, VEC[i].cfg,
                 VEC[i].st, VEC[i].dd, VEC[i].stall);
        end

        // R8: capture on the last nibble with an empty buffer starts directly
        step("R8 first capture",   BR|VAR, 32'h00004321, 2'd1, 4'h5, 4'h0, 1'b0);
        step("R8 marker",          11'h0,  32'h0,        2'd1, 4'h9, 4'h0, 1'b0);
        step("R8 nibble 0",        11'h0,  32'h0,        2'd1, 4'h0, 4'h1, 1'b0);
        step("R8 nibble 1",        11'h0,  32'h0,        2'd1, 4'h0, 4'h2, 1'b0);
        step("R8 nibble 2",        11'h0,  32'h0,        2'd1, 4'h0, 4'h3, 1'b0);
        step("R8 capture on last", BR|VAR, 32'h00008765, 2'd1, 4'h5, 4'h4, 1'b0);
        step("R8 direct marker",   11'h0,  32'h0,        2'd1, 4'h9, 4'h0, 1'b0);
        step("R8 new nibble 0",    11'h0,  32'h0,        2'd1, 4'h0, 4'h5, 1'b0);

        // R9: reset in the middle of a stream with the buffer full
        step("R9 pre capture",     BR|VAR, 32'hCAFE0123, 2'd3, 4'h5, 4'h6, 1'b1);
        step("R9 pre stream",      11'h0,  32'h0,        2'd3, 4'h0, 4'h7, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R9 async clear", 4'h0, 4'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R9 no resume a",     11'h0,  32'h0,        2'd3, 4'h0, 4'h0, 1'b0);
        step("R9 no resume b",     11'h0,  32'h0,        2'd3, 4'h0, 4'h0, 1'b0);
        step("R9 no resume c",     11'h0,  32'h0,        2'd3, 4'h0, 4'h0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule